// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This controller writes a block of bytes into a parallel UV/OTP EPROM with a pulse-and-verify loop. Software or a host engine gives a start address and a byte count and raises `start` for one cycle. The sequencer then raises the supplies in a safe order through a request/acknowledge link, takes bytes from a valid/ready source, and drives the address, the data bus, chip enable, output enable and the program strobe with every setup and hold gap counted in clock cycles.

Each byte gets fixed-width program pulses. A verify read follows every pulse. As soon as the byte reads back correctly the sequencer moves to the next address, with no extra pulse. A byte that still differs after the retry limit ends the run as a failure. When every byte has passed, the program voltage is removed and the whole block is read back twice: first at the high margin core level, then at the low margin core level.

The source must present the block three times, in ascending address order: once for programming and once for each read-back pass. The source is consumed only while `src_ready` is high.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, and while idle, the outputs are quiet. `prom_ce_n`, `prom_oe_n` and `prom_pgm_n` are high, and `prom_doe`, `vpp_on`, `sup_req`, `busy`, `done` and `fail` are low. `vcc_sel` is 0.
- R2: The core level encoding of `vcc_sel` is 0 nominal, 1 programming level, 2 high margin and 3 low margin. `vpp_on` is high only while `vcc_sel` is 1. The core level is raised and acknowledged before `vpp_on` rises, and `vpp_on` is dropped and acknowledged before the core level changes. A request holds `sup_req` high until a cycle with `sup_ack` high.
- R3: `prom_pgm_n` goes low only with `prom_ce_n` low, `prom_doe` high and `vpp_on` high. Each low pulse lasts exactly PULSE_CYCLES cycles.
- R4: `prom_addr`, `prom_dout`, `prom_doe` and `prom_ce_n` stay unchanged for at least SETUP_CYCLES-1 cycles before `prom_pgm_n` falls. `prom_addr`, `prom_dout` and `prom_doe` stay unchanged for at least SETUP_CYCLES cycles after it rises.
- R5: `prom_oe_n` goes low only while `prom_doe` is low and `prom_pgm_n` is high. `prom_doe` has been low for at least SETUP_CYCLES-1 cycles when `prom_oe_n` falls.
- R6: A byte that first reads correctly after k pulses, where k is at most MAX_PULSES, receives exactly k pulses.
- R7: A byte still wrong after MAX_PULSES pulses ends the run. The run reports `fail`=1, `fail_addr`=that address and `fail_phase`=0. No pulse goes to any later address, and no read-back takes place.
- R8: After programming, each address of the block is read exactly once with `vcc_sel`=2 and then exactly once with `vcc_sel`=3, while `vpp_on` is low. A mismatch ends the run with `fail`=1 and `fail_addr`=that address. `fail_phase` is 1 for the high margin pass and 2 for the low margin pass. The low margin pass is skipped after a failure in the high margin pass.
- R9: Every run ends with a single-cycle `done` pulse, with `busy` low, `vpp_on` low and `vcc_sel`=0. `fail` is low after a fully successful run.
- R10: A `start` raised while `busy` is high is ignored: no byte outside the running block is pulsed.
- R11: A byte count of 0 gives a `done` pulse with no supply request and no program pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (single-cycle pulse) |
| start_addr | input | AW | First address of the block |
| byte_count | input | AW+1 | Number of bytes in the block |
| src_valid | input | 1 | Source byte available |
| src_data | input | DW | Source byte |
| src_ready | output | 1 | Sequencer takes the source byte |
| prom_addr | output | AW | EPROM address bus |
| prom_dout | output | DW | Data driven toward the EPROM |
| prom_din | input | DW | Data read from the EPROM |
| prom_doe | output | 1 | Drive enable for the data bus |
| prom_ce_n | output | 1 | Chip enable, active low |
| prom_oe_n | output | 1 | Output enable, active low |
| prom_pgm_n | output | 1 | Program strobe, active low |
| vcc_sel | output | 2 | Requested core supply level |
| vpp_on | output | 1 | Request for the program voltage |
| sup_req | output | 1 | Supply change pending |
| sup_ack | input | 1 | Supply change settled |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (single-cycle pulse) |
| fail | output | 1 | Last run failed |
| fail_addr | output | AW | Address that failed |
| fail_phase | output | 2 | Phase of the failure: 0 program, 1 high margin, 2 low margin |

## Verification
The timing properties assume that `sup_ack` is high only while `sup_req` is high. They also assume that `prom_din` depends only on the address, the output enable and the current supply level. The bench's supply model raises the acknowledge a few cycles into each request and drops it as soon as the request falls. Its EPROM model answers reads combinationally from a byte array. That model clears bits only on a strobe rising edge that arrives after a per-address number of pulses, and it flips one bit of chosen addresses at a chosen margin level. The source model holds its data as a function of the current address and drops `src_valid` every third cycle, so that handshake stalls fall inside fetch states.

// File: rtl/eps_pkg.sv
package eps_pkg;
  localparam logic [1:0] VCC_NOM  = 2'd0;
  localparam logic [1:0] VCC_PROG = 2'd1;
  localparam logic [1:0] VCC_MHI  = 2'd2;
  localparam logic [1:0] VCC_MLO  = 2'd3;

  localparam logic [1:0] PH_PROG  = 2'd0;
  localparam logic [1:0] PH_MHI   = 2'd1;
  localparam logic [1:0] PH_MLO   = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_SUP, S_SUPDONE, S_FETCH, S_SETUP, S_PULSE, S_HOLD,
    S_GAP, S_VFY, S_FLOAT, S_RB_FETCH, S_RB_OE, S_RB_FLOAT, S_FINISH
  } seq_st_t;

  typedef enum logic [2:0] {
    ST_UP_VCC, ST_UP_VPP, ST_DN_VPP, ST_VCC_HI, ST_VCC_LO, ST_END_VPP, ST_END_VCC
  } sup_step_t;
endpackage

// File: rtl/eps_timer.sv
module eps_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/eps_walker.sv
module eps_walker #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic [AW-1:0] init_addr,
  input  logic [AW:0]   init_cnt,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      rem  <= '0;
    end else if (init) begin
      addr <= init_addr;
      rem  <= init_cnt;
    end else if (step) begin
      addr <= addr + 1'b1;
      rem  <= rem - 1'b1;
    end
  end

  assign last = (rem == {{AW{1'b0}}, 1'b1});
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eps_pkg::*;
#(
  parameter int AW           = 17,
  parameter int DW           = 8,
  parameter int PULSE_CYCLES = 10000,
  parameter int SETUP_CYCLES = 200,
  parameter int MAX_PULSES   = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW:0]   byte_count,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_ready,
  output logic [AW-1:0] prom_addr,
  output logic [DW-1:0] prom_dout,
  input  logic [DW-1:0] prom_din,
  output logic          prom_doe,
  output logic          prom_ce_n,
  output logic          prom_oe_n,
  output logic          prom_pgm_n,
  output logic [1:0]    vcc_sel,
  output logic          vpp_on,
  output logic          sup_req,
  input  logic          sup_ack,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [1:0]    fail_phase
);
  localparam int MAXD = (PULSE_CYCLES > SETUP_CYCLES) ? PULSE_CYCLES : SETUP_CYCLES;
  localparam int TW   = $clog2(MAXD + 1);
  localparam int PCW  = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0]  PULSE_LD = TW'(PULSE_CYCLES - 1);
  localparam logic [TW-1:0]  SETUP_LD = TW'(SETUP_CYCLES - 1);
  localparam logic [PCW-1:0] PCNT_MAX = PCW'(MAX_PULSES);

  seq_st_t       st;
  sup_step_t     step;
  logic [AW-1:0] base_addr;
  logic [AW:0]   base_cnt;
  logic [DW-1:0] data_q;
  logic [PCW-1:0] pcnt;
  logic          match, pass_lo;
  logic          t_zero, t_load, timed, accept;
  logic [TW-1:0] t_val;
  logic          wk_init, wk_step, wk_last;
  logic [AW-1:0] wk_addr_in;
  logic [AW:0]   wk_cnt_in;

  assign src_ready = (st == S_FETCH) || (st == S_RB_FETCH);
  assign accept    = src_ready && src_valid;
  assign timed     = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD) || (st == S_GAP) ||
                     (st == S_VFY) || (st == S_FLOAT) || (st == S_RB_OE) || (st == S_RB_FLOAT);
  assign t_load    = accept || (timed && t_zero);
  assign t_val     = (st == S_SETUP) ? PULSE_LD : SETUP_LD;

  assign wk_init    = ((st == S_IDLE) && start) ||
                      ((st == S_SUPDONE) && ((step == ST_VCC_HI) || (step == ST_VCC_LO)));
  assign wk_addr_in = (st == S_IDLE) ? start_addr : base_addr;
  assign wk_cnt_in  = (st == S_IDLE) ? byte_count : base_cnt;
  assign wk_step    = ((st == S_FLOAT) || (st == S_RB_FLOAT)) && t_zero && match && !wk_last;
  assign prom_dout  = data_q;

  eps_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  eps_walker #(.AW(AW)) u_walker (
    .clk(clk), .rst(rst), .init(wk_init), .init_addr(wk_addr_in), .init_cnt(wk_cnt_in),
    .step(wk_step), .addr(prom_addr), .last(wk_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  step <= ST_UP_VCC;
      base_addr <= '0;  base_cnt <= '0;  data_q <= '0;  pcnt <= '0;
      match <= 1'b0;  pass_lo <= 1'b0;
      prom_doe <= 1'b0;  prom_ce_n <= 1'b1;  prom_oe_n <= 1'b1;  prom_pgm_n <= 1'b1;
      vcc_sel <= VCC_NOM;  vpp_on <= 1'b0;  sup_req <= 1'b0;
      busy <= 1'b0;  done <= 1'b0;  fail <= 1'b0;  fail_addr <= '0;  fail_phase <= PH_PROG;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          fail <= 1'b0;  fail_addr <= '0;  fail_phase <= PH_PROG;
          base_addr <= start_addr;  base_cnt <= byte_count;  busy <= 1'b1;
          if (byte_count == '0) st <= S_FINISH;
          else begin
            vcc_sel <= VCC_PROG;  step <= ST_UP_VCC;  sup_req <= 1'b1;  st <= S_SUP;
          end
        end
        S_SUP: if (sup_ack) begin
          sup_req <= 1'b0;  st <= S_SUPDONE;
        end
        S_SUPDONE: begin
          case (step)
            ST_UP_VCC:  begin vpp_on <= 1'b1; step <= ST_UP_VPP; sup_req <= 1'b1; st <= S_SUP; end
            ST_UP_VPP:  begin prom_ce_n <= 1'b0; pcnt <= '0; st <= S_FETCH; end
            ST_DN_VPP:  begin vcc_sel <= VCC_MHI; step <= ST_VCC_HI; sup_req <= 1'b1; st <= S_SUP; end
            ST_VCC_HI:  begin prom_ce_n <= 1'b0; pass_lo <= 1'b0; st <= S_RB_FETCH; end
            ST_VCC_LO:  begin prom_ce_n <= 1'b0; pass_lo <= 1'b1; st <= S_RB_FETCH; end
            ST_END_VPP: begin vcc_sel <= VCC_NOM; step <= ST_END_VCC; sup_req <= 1'b1; st <= S_SUP; end
            default:    st <= S_FINISH;
          endcase
        end
        S_FETCH: if (src_valid) begin
          data_q <= src_data;  prom_doe <= 1'b1;  st <= S_SETUP;
        end
        S_SETUP: if (t_zero) begin prom_pgm_n <= 1'b0; st <= S_PULSE; end
        S_PULSE: if (t_zero) begin prom_pgm_n <= 1'b1; pcnt <= pcnt + 1'b1; st <= S_HOLD; end
        S_HOLD:  if (t_zero) begin prom_doe <= 1'b0; st <= S_GAP; end
        S_GAP:   if (t_zero) begin prom_oe_n <= 1'b0; st <= S_VFY; end
        S_VFY:   if (t_zero) begin
          prom_oe_n <= 1'b1;  match <= (prom_din == data_q);  st <= S_FLOAT;
        end
        S_FLOAT: if (t_zero) begin
          if (match) begin
            pcnt <= '0;
            if (wk_last) begin
              vpp_on <= 1'b0;  prom_ce_n <= 1'b1;  step <= ST_DN_VPP;  sup_req <= 1'b1;  st <= S_SUP;
            end else st <= S_FETCH;
          end else if (pcnt == PCNT_MAX) begin
            fail <= 1'b1;  fail_addr <= prom_addr;  fail_phase <= PH_PROG;
            vpp_on <= 1'b0;  prom_ce_n <= 1'b1;  step <= ST_END_VPP;  sup_req <= 1'b1;  st <= S_SUP;
          end else begin
            prom_doe <= 1'b1;  st <= S_SETUP;
          end
        end
        S_RB_FETCH: if (src_valid) begin
          data_q <= src_data;  prom_oe_n <= 1'b0;  st <= S_RB_OE;
        end
        S_RB_OE: if (t_zero) begin
          prom_oe_n <= 1'b1;  match <= (prom_din == data_q);  st <= S_RB_FLOAT;
        end
        S_RB_FLOAT: if (t_zero) begin
          if (!match) begin
            fail <= 1'b1;  fail_addr <= prom_addr;  fail_phase <= pass_lo ? PH_MLO : PH_MHI;
            prom_ce_n <= 1'b1;  vcc_sel <= VCC_NOM;  step <= ST_END_VCC;  sup_req <= 1'b1;  st <= S_SUP;
          end else if (wk_last) begin
            prom_ce_n <= 1'b1;  sup_req <= 1'b1;  st <= S_SUP;
            if (pass_lo) begin vcc_sel <= VCC_NOM; step <= ST_END_VCC; end
            else         begin vcc_sel <= VCC_MLO; step <= ST_VCC_LO;  end
          end else st <= S_RB_FETCH;
        end
        S_FINISH: begin
          done <= 1'b1;  busy <= 1'b0;  prom_ce_n <= 1'b1;  st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eps_checks.sv
module eps_checks #(
  parameter int AW           = 17,
  parameter int DW           = 8,
  parameter int PULSE_CYCLES = 10000,
  parameter int SETUP_CYCLES = 200
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] prom_addr,
  input logic [DW-1:0] prom_dout,
  input logic          prom_doe,
  input logic          prom_ce_n,
  input logic          prom_oe_n,
  input logic          prom_pgm_n,
  input logic [1:0]    vcc_sel,
  input logic          vpp_on,
  input logic          busy,
  input logic          done
);
  logic [AW+DW+1:0] sig, sig_prev;
  logic [31:0]      low_cnt, stab_cnt;

  assign sig = {prom_addr, prom_dout, prom_doe, prom_ce_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_prev <= '0;  low_cnt <= '0;  stab_cnt <= '0;
    end else begin
      sig_prev <= sig;
      low_cnt  <= prom_pgm_n ? 32'd0 : low_cnt + 32'd1;
      if (sig != sig_prev)                stab_cnt <= 32'd0;
      else if (stab_cnt != 32'hFFFF_FFFF) stab_cnt <= stab_cnt + 32'd1;
    end
  end

  p_vpp_needs_prog_r2: assert property (@(posedge clk) disable iff (rst)
    vpp_on |-> (vcc_sel == 2'd1));

  p_pulse_context_r3: assert property (@(posedge clk) disable iff (rst)
    !prom_pgm_n |-> (!prom_ce_n && prom_doe && vpp_on));

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(prom_pgm_n) |-> (low_cnt == 32'(PULSE_CYCLES)));

  p_setup_before_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(prom_pgm_n) |-> (stab_cnt >= 32'(SETUP_CYCLES - 1)));

  p_bus_free_on_read_r5: assert property (@(posedge clk) disable iff (rst)
    !prom_oe_n |-> (!prom_doe && prom_pgm_n));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_supplies_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (!vpp_on && vcc_sel == 2'd0));
endmodule

bind eprom_prog_seq eps_checks #(
  .AW(AW), .DW(DW), .PULSE_CYCLES(PULSE_CYCLES), .SETUP_CYCLES(SETUP_CYCLES)
) u_eps_checks (
  .clk(clk), .rst(rst), .prom_addr(prom_addr), .prom_dout(prom_dout),
  .prom_doe(prom_doe), .prom_ce_n(prom_ce_n), .prom_oe_n(prom_oe_n),
  .prom_pgm_n(prom_pgm_n), .vcc_sel(vcc_sel), .vpp_on(vpp_on),
  .busy(busy), .done(done)
);

// File: tb/eprom_prog_seq_bench.sv
`timescale 1ns/1ps
module eprom_prog_seq_bench;
  localparam int AW = 8, DW = 8, PULSE = 20, SETUP = 4, MAXP = 25;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW:0]   byte_count = '0;
  logic src_valid = 1'b0, src_ready;
  logic [DW-1:0] src_data, prom_dout, prom_din;
  logic [AW-1:0] prom_addr, fail_addr;
  logic prom_doe, prom_ce_n, prom_oe_n, prom_pgm_n, vpp_on, sup_req, sup_ack;
  logic busy, done, fail;
  logic [1:0] vcc_sel, fail_phase;

  always #5 clk = ~clk;

  eprom_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYCLES(PULSE), .SETUP_CYCLES(SETUP),
                   .MAX_PULSES(MAXP)) u_eprom_prog_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .byte_count(byte_count),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .prom_addr(prom_addr), .prom_dout(prom_dout), .prom_din(prom_din), .prom_doe(prom_doe),
    .prom_ce_n(prom_ce_n), .prom_oe_n(prom_oe_n), .prom_pgm_n(prom_pgm_n),
    .vcc_sel(vcc_sel), .vpp_on(vpp_on), .sup_req(sup_req), .sup_ack(sup_ack),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr), .fail_phase(fail_phase));

  function automatic logic [7:0] pat(input logic [7:0] a);
    return (a * 8'd29) ^ 8'h5A;
  endfunction
  function automatic int need_of(input logic [7:0] a);
    if (a == 8'h12) return 3;
    if (a == 8'h15) return MAXP;
    if (a == 8'h42) return MAXP + 1;
    return 1;
  endfunction
  function automatic logic [7:0] flip_of(input logic [7:0] a, input logic [1:0] lvl);
    if (a == 8'h63 && lvl == 2'd3) return 8'h01;
    if (a == 8'h74 && lvl == 2'd2) return 8'h80;
    return 8'h00;
  endfunction

  logic [7:0] mem [256];
  int pcount [256];
  int rd_hi [256];
  int rd_lo [256];
  int scnt = 0, cyc = 0, lowc = 0, stc = 0, hold_since = 0, doe_off = 0;
  bit hold_act = 1'b0;
  logic pgm_prev = 1'b1, oe_prev = 1'b1, req_prev = 1'b0;
  logic [AW+DW+1:0] sig_prev = '0;
  logic [AW+DW-1:0] hsig_prev = '0;
  int v_sup = 0, v_ctx = 0, v_width = 0, v_setup = 0, v_hold = 0, v_oe = 0, v_gap = 0;
  int npulse = 0, nreq = 0, ndone = 0;
  int n_chk = 0, n_bad = 0;

  assign src_data = pat(prom_addr);
  assign sup_ack  = sup_req && (scnt >= 3);
  assign prom_din = (!prom_ce_n && !prom_oe_n) ? (mem[prom_addr] ^ flip_of(prom_addr, vcc_sel)) : 8'hFF;

  always @(negedge clk) src_valid <= (cyc % 3) != 2;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    scnt <= sup_req ? scnt + 1 : 0;
    pgm_prev <= prom_pgm_n;  oe_prev <= prom_oe_n;  req_prev <= sup_req;
    sig_prev <= {prom_addr, prom_dout, prom_doe, prom_ce_n};
    hsig_prev <= {prom_addr, prom_dout};
    if (!rst) begin
      if (sup_req && !req_prev) nreq <= nreq + 1;
      if (done) ndone <= ndone + 1;
      if (vpp_on && vcc_sel != 2'd1) v_sup <= v_sup + 1;
      if (!prom_pgm_n && (prom_ce_n || !prom_doe || !vpp_on)) v_ctx <= v_ctx + 1;
      lowc <= prom_pgm_n ? 0 : lowc + 1;
      stc <= ({prom_addr, prom_dout, prom_doe, prom_ce_n} != sig_prev) ? 0 : stc + 1;
      doe_off <= prom_doe ? 0 : doe_off + 1;
      if (!prom_pgm_n && pgm_prev && stc < SETUP - 1) v_setup <= v_setup + 1;
      if (prom_pgm_n && !pgm_prev) begin
        npulse <= npulse + 1;
        if (lowc != PULSE) v_width <= v_width + 1;
        hold_act <= 1'b1;  hold_since <= 1;
        if (!prom_ce_n && vpp_on) begin
          pcount[prom_addr] <= pcount[prom_addr] + 1;
          if (pcount[prom_addr] + 1 >= need_of(prom_addr))
            mem[prom_addr] <= mem[prom_addr] & prom_dout;
        end
      end else if (hold_act) begin
        if ((({prom_addr, prom_dout} != hsig_prev) || !prom_doe) && hold_since < SETUP)
          v_hold <= v_hold + 1;
        if (hold_since >= SETUP) hold_act <= 1'b0;
        hold_since <= hold_since + 1;
      end
      if (!prom_oe_n && (prom_doe || !prom_pgm_n)) v_oe <= v_oe + 1;
      if (!prom_oe_n && oe_prev) begin
        if (doe_off < SETUP - 1) v_gap <= v_gap + 1;
        if (!vpp_on && vcc_sel == 2'd2) rd_hi[prom_addr] <= rd_hi[prom_addr] + 1;
        if (!vpp_on && vcc_sel == 2'd3) rd_lo[prom_addr] <= rd_lo[prom_addr] + 1;
      end
    end
  end

  bit wd_hit = 1'b0;
  always @(posedge clk) if (cyc > 150000 && !wd_hit) wd_hit <= 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin pcount[i] = 0; rd_hi[i] = 0; rd_lo[i] = 0; end
  endtask

  task automatic run_seq(input logic [7:0] a, input int n);
    @(negedge clk);
    start = 1'b1;  start_addr = a;  byte_count = 9'(n);
    @(negedge clk);
    start = 1'b0;
    while (!done && !wd_hit) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(prom_ce_n && prom_oe_n && prom_pgm_n, "R1 strobes high", {prom_ce_n, prom_oe_n, prom_pgm_n}, 7);
    chk(!prom_doe && !vpp_on && !sup_req && vcc_sel == 2'd0, "R1 supplies idle",
        {prom_doe, vpp_on, sup_req, vcc_sel}, 0);
    chk(!busy && !done && !fail, "R1 status idle", {busy, done, fail}, 0);
  endtask

  task automatic t_basic();
    int bad_p = 0, bad_m = 0, bad_r = 0, stray = 0, p0;
    clear_logs();  p0 = npulse;
    fork
      run_seq(8'h10, 8);
      begin
        repeat (300) @(negedge clk);
        start = 1'b1;  start_addr = 8'hA0;  byte_count = 9'd5;  // R10 start while busy
        @(negedge clk);  start = 1'b0;
      end
    join
    chk(done && !fail && !busy, "R9 success done", {done, fail, busy}, 4);
    chk(!vpp_on && vcc_sel == 2'd0, "R9 supplies back", {vpp_on, vcc_sel}, 0);
    for (int a = 8'h10; a < 8'h18; a++) begin
      if (pcount[a] != need_of(8'(a))) bad_p++;
      if (mem[a] != pat(8'(a))) bad_m++;
      if (rd_hi[a] != 1 || rd_lo[a] != 1) bad_r++;
    end
    for (int a = 8'hA0; a < 8'hA5; a++) stray += pcount[a];
    chk(bad_p == 0, "R6 pulses per byte", bad_p, 0);
    chk(npulse - p0 == 34, "R6 total pulses", npulse - p0, 34);
    chk(bad_m == 0, "R6 programmed content", bad_m, 0);
    chk(bad_r == 0, "R8 two read-back passes", bad_r, 0);
    chk(stray == 0, "R10 busy start ignored", stray, 0);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  task automatic t_fail_prog();
    int rds = 0;
    clear_logs();
    run_seq(8'h40, 4);
    chk(fail && fail_addr == 8'h42 && fail_phase == 2'd0, "R7 fail report",
        {fail, fail_addr, fail_phase}, {1'b1, 8'h42, 2'd0});
    chk(pcount[8'h42] == MAXP, "R7 pulse limit", pcount[8'h42], MAXP);
    chk(pcount[8'h43] == 0, "R7 no later pulse", pcount[8'h43], 0);
    for (int a = 8'h40; a < 8'h44; a++) rds += rd_hi[a] + rd_lo[a];
    chk(rds == 0, "R7 no read-back", rds, 0);
    chk(!vpp_on && vcc_sel == 2'd0 && !busy, "R9 supplies after fail", {vpp_on, vcc_sel, busy}, 0);
  endtask

  task automatic t_fail_lo();
    int hi = 0;
    clear_logs();
    run_seq(8'h60, 6);
    chk(fail && fail_addr == 8'h63 && fail_phase == 2'd2, "R8 low margin fail",
        {fail, fail_addr, fail_phase}, {1'b1, 8'h63, 2'd2});
    for (int a = 8'h60; a < 8'h66; a++) hi += rd_hi[a];
    chk(hi == 6, "R8 high pass complete first", hi, 6);
    chk(rd_lo[8'h64] == 0, "R8 stop at low fail", rd_lo[8'h64], 0);
  endtask

  task automatic t_fail_hi();
    int lo = 0;
    clear_logs();
    run_seq(8'h70, 8);
    chk(fail && fail_addr == 8'h74 && fail_phase == 2'd1, "R8 high margin fail",
        {fail, fail_addr, fail_phase}, {1'b1, 8'h74, 2'd1});
    for (int a = 8'h70; a < 8'h78; a++) lo += rd_lo[a];
    chk(lo == 0, "R8 low pass skipped", lo, 0);
  endtask

  task automatic t_single_top();
    clear_logs();
    run_seq(8'hFF, 1);
    chk(!fail && mem[8'hFF] == pat(8'hFF) && pcount[8'hFF] == 1, "R6 single top byte",
        {fail, pcount[8'hFF]}, 1);
    chk(rd_hi[8'hFF] == 1 && rd_lo[8'hFF] == 1, "R8 single byte passes", rd_hi[8'hFF] + rd_lo[8'hFF], 2);
  endtask

  task automatic t_zero();
    int r0 = nreq, p0 = npulse;
    run_seq(8'h30, 0);
    chk(done && !fail, "R11 empty run done", {done, fail}, 2);
    chk(nreq == r0 && npulse == p0, "R11 no supply or pulse", (nreq - r0) + (npulse - p0), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'hFF; pcount[i] = 0; rd_hi[i] = 0; rd_lo[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_fail_prog();
    t_fail_lo();
    t_fail_hi();
    t_single_top();
    t_zero();
    repeat (3) @(negedge clk);
    chk(v_sup == 0, "R2 program voltage only at programming level", v_sup, 0);
    chk(v_ctx == 0, "R3 strobe context", v_ctx, 0);
    chk(v_width == 0, "R3 strobe width", v_width, 0);
    chk(v_setup == 0, "R4 setup before strobe", v_setup, 0);
    chk(v_hold == 0, "R4 hold after strobe", v_hold, 0);
    chk(v_oe == 0 && v_gap == 0, "R5 read bus free", v_oe + v_gap, 0);
    chk(ndone == 6, "R9 one done per run", ndone, 6);
    chk(!wd_hit, "watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (wd_hit);
    @(negedge clk);
    n_chk++;  n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule